// File: doc/BRIEF.md
# Three-Wide Register Rename Stage

This block renames a group of up to three decoded instructions in a single cycle. Each slot carries two architectural source registers and one destination register. The stage reads a register alias table for every source and destination. Each slot that writes a register takes a fresh physical tag from a free list. At the end of the cycle the stage writes the new mappings back into the table.

Dependencies inside the group are resolved at rename time. A source takes the new tag of the nearest older slot in the group that writes the same architectural register. A source with no such slot reads the table. Because of this, one architectural register can hold several physical versions in flight at once. For example, three chained self-adds of one register use four versions: the original and three new ones. With a start value of 5 the chain ends at 40.

Each slot also reports the old mapping of its destination, so that the old tag can be freed at commit. A group that needs more tags than the free list holds is stalled as a whole. A release port returns one freed tag per cycle to the tail of the free list.

Top module: `rename3_stage`

## Requirements
- R1: After reset, architectural register i maps to physical tag i. The free list holds tags 32 to 63 in rising order, so the first three allocations return 32, 33 and 34.
- R2: A valid slot's source with no older writing slot in the group reads the alias table mapping.
- R3: A source that matches the destination of an older writing slot in the same group gets the new tag of the nearest such slot.
- R4: Each writing slot (valid and write flag set) gets a distinct new tag. Tags are taken from the head of the free list in slot order, from slot 0 to slot 2.
- R5: Each slot's old destination tag is the table mapping of its destination. If an older slot in the group writes the same register, it is that slot's new tag instead.
- R6: After an accepted group, the table holds, for each written register, the new tag of the youngest slot that wrote it.
- R7: When the free list holds fewer tags than the group has writing slots, ready_o is low. In that cycle no tag is taken and the table does not change.
- R8: A tag presented on the release port with rel_vld_i high joins the tail of the free list in that cycle. It is handed out again only after every tag that was already in the list.
- R9: A slot that is invalid or has its write flag clear takes no tag, does not change the table, and shows 0 on its new-tag output.
- R10: For three chained self-adds of one register starting at value 5, the tags allow in-order evaluation to reach 40 in the finally mapped version.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slot_vld_i | input | 3 | Per-slot valid |
| slot_wr_i | input | 3 | Per-slot destination write flag |
| src_a_i | input | 15 | First source register per slot, slot k at bits [5k+4:5k] |
| src_b_i | input | 15 | Second source register per slot |
| dst_i | input | 15 | Destination register per slot |
| rel_vld_i | input | 1 | Release a tag to the free list |
| rel_tag_i | input | 6 | Tag being released |
| ready_o | output | 1 | Group accepted this cycle |
| psrc_a_o | output | 18 | Physical first source per slot, slot k at bits [6k+5:6k] |
| psrc_b_o | output | 18 | Physical second source per slot |
| pdst_o | output | 18 | New destination tag per slot |
| pold_o | output | 18 | Previous mapping of the destination per slot |

## Verification
The case that is hardest to reach from the ports is a stall when the free list is nearly empty. It must coincide with a release in the same cycle and with groups that reuse the same few registers. This cycle has to be seen to leave both the table and the free list untouched. The bench holds releases back until a group of three writers cannot be served. It then runs a long sweep in which register indices come from a set of four and releases come only three cycles in four. This keeps the free list near empty, so stalls, intra-group chains, repeated destinations and reuse of released tags all occur together. A final read of all 32 mappings exposes any table update that a stalled or partly valid group should not have made.

// File: rtl/rn_pkg.sv
package rn_pkg;
  parameter int NARCH = 32;
  parameter int NPHYS = 64;
  parameter int WIDTH = 3;
  localparam int AW = $clog2(NARCH);
  localparam int PW = $clog2(NPHYS);
  localparam int CW = $clog2(NPHYS + 1);
  localparam int NFREE = NPHYS - NARCH;
endpackage

// File: rtl/rn_alias_table.sv
module rn_alias_table
  import rn_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [WIDTH-1:0][AW-1:0]      rd_a_i,
  input  logic [WIDTH-1:0][AW-1:0]      rd_b_i,
  input  logic [WIDTH-1:0][AW-1:0]      rd_d_i,
  output logic [WIDTH-1:0][PW-1:0]      map_a_o,
  output logic [WIDTH-1:0][PW-1:0]      map_b_o,
  output logic [WIDTH-1:0][PW-1:0]      map_d_o,
  input  logic [WIDTH-1:0]              we_i,
  input  logic [WIDTH-1:0][AW-1:0]      waddr_i,
  input  logic [WIDTH-1:0][PW-1:0]      wtag_i
);
  logic [PW-1:0] map_q [NARCH];

  for (genvar k = 0; k < WIDTH; k++) begin : g_rd
    assign map_a_o[k] = map_q[rd_a_i[k]];
    assign map_b_o[k] = map_q[rd_b_i[k]];
    assign map_d_o[k] = map_q[rd_d_i[k]];
  end

  // slot order: the youngest writer wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NARCH; i++) map_q[i] <= PW'(i);
    end else begin
      for (int k = 0; k < WIDTH; k++)
        if (we_i[k]) map_q[waddr_i[k]] <= wtag_i[k];
    end
  end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list
  import rn_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [CW-1:0]            pop_n_i,
  input  logic                     push_i,
  input  logic [PW-1:0]            push_tag_i,
  output logic [WIDTH-1:0][PW-1:0] peek_o,
  output logic [CW-1:0]            cnt_o
);
  logic [PW-1:0] fl_q [NPHYS];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  for (genvar k = 0; k < WIDTH; k++) begin : g_peek
    assign peek_o[k] = fl_q[head_q + PW'(k)];
  end
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NPHYS; i++)
        fl_q[i] <= (i < NFREE) ? PW'(NARCH + i) : '0;
      head_q <= '0;
      tail_q <= PW'(NFREE);
      cnt_q  <= CW'(NFREE);
    end else begin
      if (push_i) begin
        fl_q[tail_q] <= push_tag_i;
        tail_q       <= tail_q + 1'b1;
      end
      head_q <= head_q + PW'(pop_n_i);
      cnt_q  <= cnt_q - pop_n_i + CW'(push_i);
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_n_i <= cnt_q); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (32'(cnt_q) + 1 - 32'(pop_n_i)) <= NPHYS); // R8
endmodule

// File: rtl/rn_bypass.sv
module rn_bypass
  import rn_pkg::*;
(
  input  logic [WIDTH-1:0]         wr_i,
  input  logic [WIDTH-1:0][AW-1:0] src_a_i,
  input  logic [WIDTH-1:0][AW-1:0] src_b_i,
  input  logic [WIDTH-1:0][AW-1:0] dst_i,
  input  logic [WIDTH-1:0][PW-1:0] map_a_i,
  input  logic [WIDTH-1:0][PW-1:0] map_b_i,
  input  logic [WIDTH-1:0][PW-1:0] map_d_i,
  input  logic [WIDTH-1:0][PW-1:0] new_i,
  output logic [WIDTH-1:0][PW-1:0] psrc_a_o,
  output logic [WIDTH-1:0][PW-1:0] psrc_b_o,
  output logic [WIDTH-1:0][PW-1:0] pold_o
);
  // later j overrides earlier: nearest older writer wins
  always_comb begin
    for (int k = 0; k < WIDTH; k++) begin
      psrc_a_o[k] = map_a_i[k];
      psrc_b_o[k] = map_b_i[k];
      pold_o[k]   = map_d_i[k];
      for (int j = 0; j < WIDTH; j++) begin
        if (j < k && wr_i[j]) begin
          if (dst_i[j] == src_a_i[k]) psrc_a_o[k] = new_i[j];
          if (dst_i[j] == src_b_i[k]) psrc_b_o[k] = new_i[j];
          if (dst_i[j] == dst_i[k])   pold_o[k]   = new_i[j];
        end
      end
    end
  end
endmodule

// File: rtl/rename3_stage.sv
module rename3_stage
  import rn_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [WIDTH-1:0]      slot_vld_i,
  input  logic [WIDTH-1:0]      slot_wr_i,
  input  logic [WIDTH*AW-1:0]   src_a_i,
  input  logic [WIDTH*AW-1:0]   src_b_i,
  input  logic [WIDTH*AW-1:0]   dst_i,
  input  logic                  rel_vld_i,
  input  logic [PW-1:0]         rel_tag_i,
  output logic                  ready_o,
  output logic [WIDTH*PW-1:0]   psrc_a_o,
  output logic [WIDTH*PW-1:0]   psrc_b_o,
  output logic [WIDTH*PW-1:0]   pdst_o,
  output logic [WIDTH*PW-1:0]   pold_o
);
  logic [WIDTH-1:0][AW-1:0] src_a, src_b, dst;
  logic [WIDTH-1:0][PW-1:0] map_a, map_b, map_d, peek, new_tag;
  logic [WIDTH-1:0][PW-1:0] psrc_a, psrc_b, pold;
  logic [WIDTH-1:0]         wr_eff;
  logic [CW-1:0]            ndst, cnt, pop_n;

  assign src_a  = src_a_i;
  assign src_b  = src_b_i;
  assign dst    = dst_i;
  assign wr_eff = slot_vld_i & slot_wr_i;

  // hand out free-list heads to writing slots in slot order
  always_comb begin
    int acc;
    acc = 0;
    new_tag = '0;
    for (int k = 0; k < WIDTH; k++) begin
      if (wr_eff[k]) begin
        new_tag[k] = peek[acc];
        acc++;
      end
    end
    ndst = CW'(acc);
  end

  assign ready_o = (cnt >= ndst);
  assign pop_n   = ready_o ? ndst : '0;

  rn_alias_table i_rat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_a_i  (src_a),
    .rd_b_i  (src_b),
    .rd_d_i  (dst),
    .map_a_o (map_a),
    .map_b_o (map_b),
    .map_d_o (map_d),
    .we_i    (wr_eff & {WIDTH{ready_o}}),
    .waddr_i (dst),
    .wtag_i  (new_tag)
  );

  rn_free_list i_fl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pop_n_i    (pop_n),
    .push_i     (rel_vld_i),
    .push_tag_i (rel_tag_i),
    .peek_o     (peek),
    .cnt_o      (cnt)
  );

  rn_bypass i_byp (
    .wr_i     (wr_eff),
    .src_a_i  (src_a),
    .src_b_i  (src_b),
    .dst_i    (dst),
    .map_a_i  (map_a),
    .map_b_i  (map_b),
    .map_d_i  (map_d),
    .new_i    (new_tag),
    .psrc_a_o (psrc_a),
    .psrc_b_o (psrc_b),
    .pold_o   (pold)
  );

  assign psrc_a_o = psrc_a;
  assign psrc_b_o = psrc_b;
  assign pdst_o   = new_tag;
  assign pold_o   = pold;

  for (genvar k = 0; k < WIDTH; k++) begin : g_ast
    AST_OLD_NE_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_o && wr_eff[k]) |-> pold[k] != new_tag[k]); // R5
    for (genvar j = k + 1; j < WIDTH; j++) begin : g_pair
      AST_NEW_DISTINCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o && wr_eff[k] && wr_eff[j]) |-> new_tag[k] != new_tag[j]); // R4
    end
  end

  AST_CHAIN_SLOT1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && wr_eff[0] && slot_vld_i[1] && src_a[1] == dst[0])
      |-> psrc_a[1] == new_tag[0]); // R3
  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !rel_vld_i) |=> $stable(cnt)); // R7
endmodule

// File: tb/test_rename3_stage.sv
module test_rename3_stage;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  slot_vld_i = '0, slot_wr_i = '0;
  logic [14:0] src_a_i = '0, src_b_i = '0, dst_i = '0;
  logic        rel_vld_i = 1'b0;
  logic [5:0]  rel_tag_i = '0;
  logic        ready_o;
  logic [17:0] psrc_a_o, psrc_b_o, pdst_o, pold_o;

  rename3_stage i_rename3_stage (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int errors = 0, checks = 0;
  int mrat[32];
  int mfq[$];
  int pend[$];
  int pv[64];
  int g_sa[3], g_sb[3], g_d[3];
  logic [2:0] g_v, g_w;
  int o_a[3], o_b[3], o_d[3];
  logic [31:0] rng = 32'h1234_5678;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic step(input bit rel_en);
    int ndst, off, acc;
    int newt[3], ea[3], eb[3], eo[3];
    bit ok, ba, bb;
    bit do_rel;
    int rtag;
    @(negedge clk_i);
    slot_vld_i = g_v;
    slot_wr_i  = g_w;
    for (int k = 0; k < 3; k++) begin
      src_a_i[k*5 +: 5] = 5'(g_sa[k]);
      src_b_i[k*5 +: 5] = 5'(g_sb[k]);
      dst_i[k*5 +: 5]   = 5'(g_d[k]);
    end
    do_rel = rel_en && pend.size() > 0;
    rtag = do_rel ? pend.pop_front() : 0;
    rel_vld_i = do_rel;
    rel_tag_i = 6'(rtag);
    #1;
    ndst = 0;
    for (int k = 0; k < 3; k++) if (g_v[k] && g_w[k]) ndst++;
    ok = mfq.size() >= ndst;
    chk("R7 ready", int'(ready_o), int'(ok));
    for (int k = 0; k < 3; k++) begin
      o_a[k] = int'(psrc_a_o[k*6 +: 6]);
      o_b[k] = int'(psrc_b_o[k*6 +: 6]);
      o_d[k] = int'(pdst_o[k*6 +: 6]);
    end
    if (ok) begin
      off = 0;
      for (int k = 0; k < 3; k++) begin
        newt[k] = 0;
        if (g_v[k] && g_w[k]) begin newt[k] = mfq[off]; off++; end
      end
      for (int k = 0; k < 3; k++) begin
        ea[k] = mrat[g_sa[k]]; eb[k] = mrat[g_sb[k]]; eo[k] = mrat[g_d[k]];
        ba = 0; bb = 0;
        for (int j = 0; j < k; j++) begin
          if (g_v[j] && g_w[j]) begin
            if (g_d[j] == g_sa[k]) begin ea[k] = newt[j]; ba = 1; end
            if (g_d[j] == g_sb[k]) begin eb[k] = newt[j]; bb = 1; end
            if (g_d[j] == g_d[k])  eo[k] = newt[j];
          end
        end
        if (g_v[k]) begin
          chk(ba ? "R3 src_a" : "R2 src_a", o_a[k], ea[k]);
          chk(bb ? "R3 src_b" : "R2 src_b", o_b[k], eb[k]);
          if (g_w[k]) begin
            chk(newt[k] < 32 ? "R8 dst" : "R4 dst", o_d[k], newt[k]);
            chk("R5 old", int'(pold_o[k*6 +: 6]), eo[k]);
          end else chk("R9 dst", o_d[k], 0);
        end else chk("R9 dst", o_d[k], 0);
      end
      acc = 0;
      for (int k = 0; k < 3; k++) begin
        if (g_v[k] && g_w[k]) begin
          void'(mfq.pop_front());
          pend.push_back(eo[k]);
          mrat[g_d[k]] = newt[k];
          acc++;
        end
      end
    end
    if (do_rel) mfq.push_back(rtag);
  endtask

  task automatic set_grp(input logic [2:0] v, input logic [2:0] w,
                         input int a0, input int b0, input int d0,
                         input int a1, input int b1, input int d1,
                         input int a2, input int b2, input int d2);
    g_v = v; g_w = w;
    g_sa[0] = a0; g_sb[0] = b0; g_d[0] = d0;
    g_sa[1] = a1; g_sb[1] = b1; g_d[1] = d1;
    g_sa[2] = a2; g_sb[2] = b2; g_d[2] = d2;
  endtask

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL R1 watchdog got=1 exp=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mrat[i] = i;
    for (int i = 32; i < 64; i++) mfq.push_back(i);
    for (int i = 0; i < 64; i++) pv[i] = 0;
    #(CLK_PERIOD * 2 + 3);
    rst_ni = 1'b1;

    // R1: reset state seen at the ports
    set_grp(3'b000, 3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0);
    chk("R1 ready after reset", int'(ready_o), 1);

    // R10: three chained self-adds of register 1
    set_grp(3'b111, 3'b111, 1, 1, 1, 1, 1, 1, 1, 1, 1);
    step(0);
    for (int k = 0; k < 3; k++) chk("R1 first tags", o_d[k], 32 + k);
    chk("R1 identity map", o_a[0], 1);
    pv[1] = 5;
    for (int k = 0; k < 3; k++) pv[o_d[k]] = pv[o_a[k]] + pv[o_b[k]];
    set_grp(3'b001, 3'b000, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    step(0);
    chk("R6 youngest mapped", o_a[0], 34);
    chk("R10 final value", pv[o_a[0]], 40);

    // R7: drain without releases until a group stalls
    for (int n = 0; n < 11; n++) begin
      set_grp(3'b111, 3'b111, n, n+1, (3*n)%32, 2, 3, (3*n+1)%32, 4, 5, (3*n+2)%32);
      step(0);
    end
    chk("R7 stalled at low free count", int'(ready_o), 0);
    set_grp(3'b111, 3'b000, 0, 1, 0, 2, 3, 0, 4, 5, 0);
    step(0);

    // R8: refill through the release port
    for (int n = 0; n < 6; n++) begin
      set_grp(3'b000, 3'b111, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step(1);
    end

    // near-exhaustive sweep over a small register set
    for (int it = 0; it < 4000; it++) begin
      rng = xs(rng);
      g_v = rng[2:0] | 3'(it % 2);
      g_w = rng[5:3];
      for (int k = 0; k < 3; k++) begin
        g_sa[k] = int'(rng[6 + k*6 +: 2]);
        g_sb[k] = int'(rng[8 + k*6 +: 2]);
        g_d[k]  = int'(rng[10 + k*6 +: 2]);
      end
      step(rng[31:30] != 2'b00);
    end

    // R6: read back all mappings
    for (int r = 0; r < 32; r++) begin
      set_grp(3'b001, 3'b000, r, r, 0, 0, 0, 0, 0, 0, 0);
      step(0);
      chk("R6 table readback", o_a[0], mrat[r]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule